// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns a group of raw interrupt request lines into a registered vector of pending requests. Each line has its own trigger-mode bit. In level mode the pending bit tracks the input. In edge mode the pending bit is set by a rising transition and stays set until an acknowledge names that line. A stored copy of each input's previous level is used to detect the rising transitions.

Software reads and writes the trigger-mode bits through a byte-wide configuration port. Each write is ANDed with a fixed per-instance mask. Lines whose mask bit is zero are therefore always edge-triggered. A controller re-initialisation pulse clears the pending and previous-level state but keeps the trigger-mode bits. Priority resolution, masking and the processor signal belong to the logic downstream of this block.

Top module: `irq_req_latch`

## Requirements
- R1: After synchronous reset, `pend` is all zero and `cfg_rdata` is all zero, which means every line is in edge mode.
- R2: A line whose trigger-mode bit is 1 (level) has its `pend` bit equal to that line's `irq_in` value sampled at the previous clock edge. This holds whether the input is high or low.
- R3: A line whose trigger-mode bit is 0 (edge) sets its `pend` bit one cycle after its input is first sampled high when it was sampled low before. An input that stays high does not set the bit again once it has been acknowledged.
- R4: In edge mode a low input does not clear a pending bit that is already set.
- R5: A cycle with `ack_valid` high clears the `pend` bit of edge-mode line `ack_idx` at the next edge. The other lines are left unchanged.
- R6: An acknowledge of a level-mode line has no effect on that line. The bit stays set while the input stays high.
- R7: A `cfg_wr` stores `cfg_wdata & WR_MASK` into the trigger-mode bits, and `cfg_rdata` returns the stored value from the next cycle on. With the default mask 8'hF8, lines 0 to 2 can never be set to level.
- R8: A `reinit` pulse clears `pend` and the previous-level copies at the next edge and leaves the trigger-mode bits unchanged. An edge-mode input that is still high after the pulse therefore sets its pending bit again one cycle later.
- R9: If an edge-mode line rises in the same cycle in which it is acknowledged, the new request wins and the `pend` bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_LINES | Raw request lines |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Index of the acknowledged line |
| cfg_wr | input | 1 | Write strobe for the trigger-mode bits |
| cfg_wdata | input | N_LINES | Write data; 1 selects level, 0 selects edge |
| cfg_rdata | output | N_LINES | Stored trigger-mode bits |
| reinit | input | 1 | Controller re-initialisation pulse |
| pend | output | N_LINES | Pending-request vector |

## Verification
The bound checker checks four things on every cycle:
- Level-mode bits track the previous input sample.
- Edge-mode bits never drop without an acknowledge or a re-initialisation.
- A configuration write reads back masked.
- A re-initialisation empties the pending vector without touching the mode bits.

Only the directed scenarios can show the rest. These are that an edge fires once per rising transition, that the new request wins when it collides with an acknowledge, and that a held-high edge line re-arms after re-initialisation.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    typedef struct packed {
        logic  raw;
        logic  ack;
        trig_e mode;
    } line_in_t;

    // Next value of one pending bit, ignoring reinit.
    function automatic logic pend_next(line_in_t li, logic prev, logic cur);
        logic rise;
        rise = li.raw & ~prev;
        if (li.mode == TRIG_LEVEL)
            return li.raw;
        else
            return rise | (cur & ~li.ack);
    endfunction

endpackage

// File: rtl/irq_trig_mode_reg.sv
module irq_trig_mode_reg #(
    parameter int               N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = 8'hF8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] mode_q
);
    // Not cleared by reinit: only hardware reset touches it.
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= '0;
        else if (wr)
            mode_q <= wdata & WR_MASK;
    end
endmodule

// File: rtl/irq_line_cell.sv
module irq_line_cell
    import irq_latch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     reinit,
    input  line_in_t li,
    output logic     pend_o
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst || reinit) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= li.raw;
            pend_q <= pend_next(li, prev_q, pend_q);
        end
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
    import irq_latch_pkg::*;
#(
    parameter int               N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = 8'hF8,
    localparam int              IDX_W   = $clog2(N_LINES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               ack_valid,
    input  logic [IDX_W-1:0]   ack_idx,
    input  logic               cfg_wr,
    input  logic [N_LINES-1:0] cfg_wdata,
    output logic [N_LINES-1:0] cfg_rdata,
    input  logic               reinit,
    output logic [N_LINES-1:0] pend
);
    logic [N_LINES-1:0] mode_q;
    logic [N_LINES-1:0] ack_hot;

    irq_trig_mode_reg #(.N_LINES(N_LINES), .WR_MASK(WR_MASK)) u_mode (
        .clk    (clk),
        .rst    (rst),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .mode_q (mode_q)
    );

    always_comb begin
        ack_hot = '0;
        if (ack_valid)
            ack_hot[ack_idx] = 1'b1;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        line_in_t li;
        assign li.raw  = irq_in[i];
        assign li.ack  = ack_hot[i];
        assign li.mode = trig_e'(mode_q[i]);

        irq_line_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .reinit (reinit),
            .li     (li),
            .pend_o (pend[i])
        );
    end

    assign cfg_rdata = mode_q;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int               N_LINES = 8,
    parameter logic [N_LINES-1:0] WR_MASK = 8'hF8
) (
    input logic               clk,
    input logic               rst,
    input logic [N_LINES-1:0] irq_in,
    input logic               ack_valid,
    input logic               cfg_wr,
    input logic [N_LINES-1:0] cfg_wdata,
    input logic [N_LINES-1:0] cfg_rdata,
    input logic               reinit,
    input logic [N_LINES-1:0] pend
);
    assert_level_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (!reinit && !cfg_wr) |=> ((pend & cfg_rdata) == ($past(irq_in) & cfg_rdata)));

    assert_edge_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!reinit && !ack_valid && !cfg_wr) |=> ((~cfg_rdata & $past(pend) & ~pend) == '0));

    assert_write_masked_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_rdata == ($past(cfg_wdata) & WR_MASK)));

    assert_reinit_clear_R8: assert property (@(posedge clk) disable iff (rst)
        reinit |=> (pend == '0));

    assert_reinit_keeps_mode_R8: assert property (@(posedge clk) disable iff (rst)
        (reinit && !cfg_wr) |=> $stable(cfg_rdata));
endmodule

bind irq_req_latch irq_req_latch_chk #(.N_LINES(N_LINES), .WR_MASK(WR_MASK)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq_in    (irq_in),
    .ack_valid (ack_valid),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .reinit    (reinit),
    .pend      (pend)
);

// File: tb/irq_req_latch_test.sv
module irq_req_latch_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] irq_in;
    logic       ack_valid;
    logic [2:0] ack_idx;
    logic       cfg_wr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic       reinit;
    logic [7:0] pend;

    int n_vec  = 0;
    int n_miss = 0;

    always #2 clk = ~clk;

    irq_req_latch uut (
        .clk(clk), .rst(rst), .irq_in(irq_in), .ack_valid(ack_valid),
        .ack_idx(ack_idx), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .reinit(reinit), .pend(pend)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_miss++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: inputs are already set at a negedge, result is sampled at the next negedge.
    task automatic tick();
        @(negedge clk);
        ack_valid = 1'b0;
        cfg_wr    = 1'b0;
        reinit    = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; irq_in = '0; ack_valid = 0; ack_idx = 0;
        cfg_wr = 0; cfg_wdata = 0; reinit = 0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk(pend, 8'h00, "R1 pend");
        chk(cfg_rdata, 8'h00, "R1 mode");
    endtask

    task automatic t_mask();
        cfg_wr = 1; cfg_wdata = 8'hFF; tick();
        chk(cfg_rdata, 8'hF8, "R7 masked ff");
        cfg_wr = 1; cfg_wdata = 8'h0F; tick();
        chk(cfg_rdata, 8'h08, "R7 masked 0f (line3 level)");
    endtask

    task automatic t_level();
        irq_in[3] = 1; tick();
        chk(pend & 8'h08, 8'h08, "R2 level high");
        ack_valid = 1; ack_idx = 3; tick();
        chk(pend & 8'h08, 8'h08, "R6 ack on level line");
        irq_in[3] = 0; tick();
        chk(pend & 8'h08, 8'h00, "R2 level low");
    endtask

    task automatic t_edge();
        irq_in[0] = 1; tick();
        chk(pend & 8'h01, 8'h01, "R3 rise sets");
        irq_in[0] = 0; tick();
        chk(pend & 8'h01, 8'h01, "R4 low keeps");
        irq_in[1] = 1; tick();
        ack_valid = 1; ack_idx = 0; tick();
        chk(pend & 8'h03, 8'h02, "R5 ack clears only line0");
        tick();
        chk(pend & 8'h02, 8'h02, "R3 held high no change");
        ack_valid = 1; ack_idx = 1; tick();
        tick();
        chk(pend & 8'h02, 8'h00, "R3 held high no re-set after ack");
    endtask

    task automatic t_collide();
        irq_in[0] = 1; tick();
        irq_in[0] = 0; tick();
        chk(pend & 8'h01, 8'h01, "R9 setup");
        irq_in[0] = 1; ack_valid = 1; ack_idx = 0; tick();
        chk(pend & 8'h01, 8'h01, "R9 rise wins over ack");
    endtask

    task automatic t_reinit();
        irq_in[3] = 1; tick();
        reinit = 1; tick();
        chk(pend, 8'h00, "R8 pend cleared");
        chk(cfg_rdata, 8'h08, "R8 mode kept");
        tick();
        chk(pend & 8'h0B, 8'h0B, "R8 held-high lines re-arm");
    endtask

    initial begin
        t_reset();
        t_mask();
        t_level();
        t_edge();
        t_collide();
        t_reinit();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_miss++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end
endmodule